// File: doc/BRIEF.md
# Serial ADC Frame Sequencer

This block is the digital control sequencer of a two-channel serial sampling converter. The host frames each transaction with an active-low frame-select line and a serial clock. The block runs on a fast system clock. It receives the frame-select level and a one-cycle pulse for every rising serial-clock edge. Within each frame it counts serial clocks and raises a sample flag for a fixed window. It then launches a fixed-latency conversion. The analog core is modelled as a down-counter, and a parallel result word is captured when that counter expires.

The previous result leaves on the serial data line during the next frame, most significant bit first. The frame length steers the channel. A short frame forces channel 0. A full frame whose conversion finished advances to the other channel when frame-select is released. Releasing frame-select early aborts a running conversion.

Data movement is paced only by frames, so no valid/ready pair is used. The result input is sampled in the cycle the conversion ends, and the core may not hold it back. The serial output cannot be stalled. A host that needs a result must clock a frame of at least 12 serial clocks.

Top module: `adc_frame_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and after it, the block selects channel 0, holds the stored result at zero, and drives `sample_o`, `busy_o`, `res_valid_o` and `sdo_o` low until a frame begins.
- R2: `sample_o` is high only while `frame_n_i` is low. It rises after the 4th serial-clock pulse of the frame and falls after the 16th, covering 12 serial clocks.
- R3: The 16th serial-clock pulse starts a conversion. `busy_o` then stays high for CONV_CYCLES system clocks, 30 by default. `res_valid_o` then pulses for one cycle and `conv_data_i` is stored as the new result.
- R4: If `frame_n_i` is high at an edge while a conversion has not yet reached its final cycle, the conversion is aborted. `busy_o` falls, no `res_valid_o` pulse is produced, and the stored result keeps its earlier value.
- R5: While `frame_n_i` is low, `sdo_o` presents bit 11-k of the stored result after k serial-clock pulses, for k from 0 to 11. It is 0 after 12 or more pulses and 0 whenever `frame_n_i` is high.
- R6: A frame that ends after 4 to 7 serial-clock pulses sets `chan_o` to 0.
- R7: A frame of 16 or more pulses whose conversion completed sets `chan_o` to the other channel when `frame_n_i` rises. This includes a conversion completing at the same edge at which the rise is seen.
- R8: A frame of 1 to 3 or 8 to 15 pulses, or one whose conversion was aborted, leaves `chan_o` unchanged. Outside a frame end, `chan_o` never changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n_i | input | 1 | Frame select, active low, synchronous to clk |
| sclk_rise_i | input | 1 | One-cycle pulse per rising serial-clock edge |
| conv_data_i | input | 12 | Parallel result from the conversion core |
| sample_o | output | 1 | Sampling window active |
| busy_o | output | 1 | Conversion in progress |
| chan_o | output | 1 | Selected input channel |
| res_valid_o | output | 1 | One-cycle pulse when a conversion completes |
| sdo_o | output | 1 | Serial result data, 0 when no frame is active |

## Verification
The conversion timer expiring and the frame-select release can land on the same edge. That edge decides both the result capture and the channel toggle. The bench makes the collision happen by releasing frame-select on exactly the last conversion cycle of a 20-clock frame, and it expects a valid pulse, a toggled channel and the new word in the next frame. A release one cycle earlier in another frame must abort instead. The bench judges that case by the missing pulse, the unchanged channel and the old word read back afterwards.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    CH_KEEP   = 2'd0,
    CH_ZERO   = 2'd1,
    CH_TOGGLE = 2'd2
  } ch_act_e;
endpackage

// File: rtl/adc_seq_frame.sv
module adc_seq_frame #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n_i,
  input  logic             sclk_rise_i,
  output logic             active_o,
  output logic             fin_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic fs_prev;

  assign active_o = ~frame_n_i;
  assign fin_o    = ~fs_prev & frame_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_prev <= 1'b1;
      cnt_o   <= '0;
    end else begin
      fs_prev <= frame_n_i;
      if (frame_n_i) begin
        cnt_o <= '0;
      end else if (sclk_rise_i && (cnt_o != {CNT_W{1'b1}})) begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_conv.sv
module adc_seq_conv #(
  parameter int RES_W       = 12,
  parameter int CNT_W       = 5,
  parameter int FRAME_LEN   = 16,
  parameter int CONV_CYCLES = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             sclk_rise_i,
  input  logic             fin_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             busy_o,
  output logic             done_now_o,
  output logic             done_seen_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o
);
  localparam int T_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAUNCH_AT = CNT_W'(FRAME_LEN - 1);
  localparam logic [T_W-1:0]   T_LOAD    = T_W'(CONV_CYCLES - 1);

  logic [T_W-1:0] tmr;
  logic           launch;

  assign launch     = active_i & sclk_rise_i & (cnt_i == LAUNCH_AT);
  assign done_now_o = busy_o & (tmr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o   <= 1'b0;
      tmr      <= '0;
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= done_now_o;
      if (done_now_o) begin
        busy_o   <= 1'b0;
        result_o <= conv_data_i;
      end else if (fin_i && busy_o) begin
        busy_o <= 1'b0;
      end else if (launch) begin
        busy_o <= 1'b1;
        tmr    <= T_LOAD;
      end else if (busy_o) begin
        tmr <= tmr - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || fin_i) begin
      done_seen_o <= 1'b0;
    end else if (done_now_o) begin
      done_seen_o <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan
  import adc_seq_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int FRAME_LEN = 16,
  parameter int ZERO_MIN  = 4,
  parameter int ZERO_MAX  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             conv_ok_i,
  output logic             chan_o
);
  localparam logic [CNT_W-1:0] Z_LO = CNT_W'(ZERO_MIN);
  localparam logic [CNT_W-1:0] Z_HI = CNT_W'(ZERO_MAX);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_LEN);

  ch_act_e act;

  always_comb begin
    if ((cnt_i >= Z_LO) && (cnt_i <= Z_HI)) begin
      act = CH_ZERO;
    end else if ((cnt_i >= FULL) && conv_ok_i) begin
      act = CH_TOGGLE;
    end else begin
      act = CH_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_o <= 1'b0;
    end else if (fin_i) begin
      case (act)
        CH_ZERO:   chan_o <= 1'b0;
        CH_TOGGLE: chan_o <= ~chan_o;
        default:   chan_o <= chan_o;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_sdo.sv
module adc_seq_sdo #(
  parameter int RES_W     = 12,
  parameter int CNT_W     = 5,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o
);
  logic [RES_W-1:0] ordered;

  generate
    if (MSB_FIRST) begin : g_msb
      for (genvar g = 0; g < RES_W; g++) begin : g_rev
        assign ordered[g] = result_i[RES_W-1-g];
      end
    end else begin : g_lsb
      assign ordered = result_i;
    end
  endgenerate

  always_comb begin
    sdo_o = 1'b0;
    for (int k = 0; k < RES_W; k++) begin
      if (active_i && (cnt_i == CNT_W'(k))) begin
        sdo_o = ordered[k];
      end
    end
  end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int RES_W        = 12,
  parameter int SAMPLE_START = 4,
  parameter int SAMPLE_LEN   = 12,
  parameter int CONV_CYCLES  = 30,
  parameter int ZERO_MIN     = 4,
  parameter int ZERO_MAX     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n_i,
  input  logic             sclk_rise_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             sample_o,
  output logic             busy_o,
  output logic             chan_o,
  output logic             res_valid_o,
  output logic             sdo_o
);
  localparam int FRAME_LEN = SAMPLE_START + SAMPLE_LEN;
  localparam int CNT_W     = $clog2(FRAME_LEN) + 1;
  localparam logic [CNT_W-1:0] S_LO = CNT_W'(SAMPLE_START);
  localparam logic [CNT_W-1:0] S_HI = CNT_W'(FRAME_LEN);

  logic             active;
  logic             fin;
  logic [CNT_W-1:0] cnt;
  logic             done_now;
  logic             done_seen;
  logic [RES_W-1:0] result;

  adc_seq_frame #(.CNT_W(CNT_W)) i_frame (
    .clk(clk), .rst(rst), .frame_n_i(frame_n_i), .sclk_rise_i(sclk_rise_i),
    .active_o(active), .fin_o(fin), .cnt_o(cnt)
  );

  adc_seq_conv #(
    .RES_W(RES_W), .CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN), .CONV_CYCLES(CONV_CYCLES)
  ) i_conv (
    .clk(clk), .rst(rst), .active_i(active), .sclk_rise_i(sclk_rise_i),
    .fin_i(fin), .cnt_i(cnt), .conv_data_i(conv_data_i),
    .busy_o(busy_o), .done_now_o(done_now), .done_seen_o(done_seen),
    .valid_o(res_valid_o), .result_o(result)
  );

  adc_seq_chan #(
    .CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN), .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX)
  ) i_chan (
    .clk(clk), .rst(rst), .fin_i(fin), .cnt_i(cnt),
    .conv_ok_i(done_seen | done_now), .chan_o(chan_o)
  );

  adc_seq_sdo #(.RES_W(RES_W), .CNT_W(CNT_W), .MSB_FIRST(1'b1)) i_sdo (
    .active_i(active), .cnt_i(cnt), .result_i(result), .sdo_o(sdo_o)
  );

  assign sample_o = active & (cnt >= S_LO) & (cnt < S_HI);
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rst,
  input logic frame_n_i,
  input logic sample_o,
  input logic busy_o,
  input logic chan_o,
  input logic res_valid_o,
  input logic sdo_o
);
  AST_SAMPLE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> !frame_n_i); // R2
  AST_SAMPLE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(sample_o && busy_o)); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |=> !res_valid_o); // R3
  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> $past(busy_o)); // R3
  AST_ABORT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_n_i) |=> !busy_o); // R4
  AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    frame_n_i |-> !sdo_o); // R5
  AST_CHAN_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$rose(frame_n_i) |=> $stable(chan_o)); // R8
endmodule

bind adc_frame_seq adc_seq_chk i_chk (
  .clk(clk), .rst(rst), .frame_n_i(frame_n_i), .sample_o(sample_o),
  .busy_o(busy_o), .chan_o(chan_o), .res_valid_o(res_valid_o), .sdo_o(sdo_o)
);

// File: tb/test_adc_frame_seq.sv
module test_adc_frame_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CONV       = 30;

  logic        clk = 1'b0;
  logic        rst;
  logic        frame_n_i;
  logic        sclk_rise_i;
  logic [11:0] conv_data_i;
  logic        sample_o, busy_o, chan_o, res_valid_o, sdo_o;

  int vectors = 0;
  int miscompares = 0;
  int frame_id = 0;
  int exp_q[$];
  logic [11:0] model_res = '0;
  logic        model_ch = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_seq i_adc_frame_seq (
    .clk(clk), .rst(rst), .frame_n_i(frame_n_i), .sclk_rise_i(sclk_rise_i),
    .conv_data_i(conv_data_i), .sample_o(sample_o), .busy_o(busy_o),
    .chan_o(chan_o), .res_valid_o(res_valid_o), .sdo_o(sdo_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h (frame %0d)", req, act, exp, frame_id);
    end
  endtask

  // Monitor: each result-valid pulse must match a frame the driver expected to complete (R3, R4)
  always @(negedge clk) begin
    if (!rst && res_valid_o) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected valid", 32'd1, 32'd0);
      end else begin
        chk("R3 valid frame", frame_id, exp_q.pop_front());
      end
    end
  end

  task automatic run_frame(input int nclk, input int gap, input logic [11:0] data);
    logic [11:0] word;
    int busy_cnt;
    int end_at;
    bit complete;
    frame_id++;
    word = '0;
    busy_cnt = 0;
    end_at = 2 + 2 * (nclk - 16) + gap;
    complete = (nclk >= 16) && (end_at >= CONV);
    if (complete) exp_q.push_back(frame_id);
    conv_data_i = data;
    frame_n_i = 1'b0;
    @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      chk("R2 sample window", sample_o, (i >= 4 && i < 16));
      if (i < 12) word[11-i] = sdo_o;
      else chk("R5 trailing zero", sdo_o, 1'b0);
      sclk_rise_i = 1'b1;
      @(negedge clk);
      sclk_rise_i = 1'b0;
      @(negedge clk);
    end
    if (nclk >= 12) chk("R5 serial word", word, model_res);
    if (nclk >= 16) chk("R3 busy after 16th clock", busy_o, 1'b1);
    for (int g = 0; g < gap; g++) begin
      if (busy_o) busy_cnt++;
      @(negedge clk);
    end
    if (nclk == 16 && gap >= CONV) chk("R3 busy length", busy_cnt, CONV - 1);
    frame_n_i = 1'b1;
    @(negedge clk);
    if (nclk >= 4 && nclk <= 7) model_ch = 1'b0;
    else if (complete) model_ch = ~model_ch;
    if (complete) model_res = data;
    chk("R6 R7 R8 channel", chan_o, model_ch);
    chk("R4 busy low after end", busy_o, 1'b0);
    chk("R5 sdo idle", sdo_o, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst = 1'b1;
    frame_n_i = 1'b1;
    sclk_rise_i = 1'b0;
    conv_data_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 chan", chan_o, 1'b0);
    chk("R1 busy", busy_o, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sample", sample_o, 1'b0);
    chk("R1 valid", res_valid_o, 1'b0);
    chk("R1 sdo", sdo_o, 1'b0);

    run_frame(16, CONV, 12'hA5C);      // R1 zero word, R7 toggle to 1
    run_frame(16, CONV, 12'h3F1);      // R5 reads A5C, R7 back to 0
    run_frame(20, CONV - 10, 12'h6B7); // R7 completion and release on one edge
    run_frame(16, CONV - 3, 12'h1E2);  // R4 release one cycle early: abort
    run_frame(10, 1, 12'h000);         // R8 mid-length frame keeps channel
    run_frame(5, 1, 12'h000);          // R6 short frame to channel 0
    run_frame(16, CONV, 12'h001);      // R4 word still 6B7
    run_frame(2, 1, 12'h000);          // R8 tiny frame keeps channel 1
    run_frame(7, 1, 12'h000);          // R6 upper bound
    run_frame(16, CONV, 12'h800);
    run_frame(4, 1, 12'h000);          // R6 lower bound
    run_frame(3, 1, 12'h000);          // R8
    run_frame(16, CONV, 12'hC3C);
    run_frame(8, 1, 12'h000);          // R8 boundary 8 keeps channel
    run_frame(12, 1, 12'h000);         // R5 reads C3C

    chk("R3 all expected completions seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule